// File: doc/BRIEF.md
# Supervisor Domain Control Register Pair

This block holds two machine-mode control registers for a single hart. The first register points at the root of the memory protection tables. It holds a protection mode, a supervisor domain identifier and a root physical page number. The second register holds per-domain configuration: an interrupt domain number, debug and trace allow bits, and quality-of-service selectors.

The block accepts one CSR access per cycle. Each access carries an address, a write enable, write data and the privilege of the requester. Every field is legalized on write, so a read always returns a legal value. The stored mode, domain ID and root page number are driven continuously to a downstream protection checker. An active flag tells that checker whether the current effective privilege level is subject to the tables.

Parameters select the register width (32 or 64 bits) and the number of implemented domain ID bits (0 to 6). A mask selects the supported modes, and four enables select which optional configuration fields exist.

Top module: `sd_csr_pair`

## Requirements
- R1: After a synchronous reset, both registers read as zero, and the protection outputs show mode 0, ID 0 and page number 0.
- R2: The pointer register answers at address 0x382 and the configuration register at 0x74E. An access to any other address gives `acc_hit`=0 and read data 0, and it changes no state.
- R3: With XLEN=64, the pointer register word has the page number in bits 43:0, the domain ID in bits 57:52 and the mode in bits 63:60. Bits 51:44 and 59:58 always read zero.
- R4: With XLEN=32, the pointer register word has the page number in bits 21:0, the domain ID in bits 27:22 and the mode in bits 31:30. Bits 29:28 always read zero.
- R5: Only the low ID_BITS bits of the domain ID are stored. Writing all ones reads back exactly 2^ID_BITS-1, and that value is 0 when ID_BITS=0.
- R6: A write whose mode is unsupported is still performed. The mode becomes 0, and the page number and domain ID are legalized and stored as usual. Mode 0 is always supported. With XLEN=32 only modes 0 and 1 can be supported; with XLEN=64 only modes 0 to 3 can be supported, and a mode is supported only if its bit in MODE_MASK is set.
- R7: With XLEN=64 and a stored mode of 3, page number bits 2:0 read as zero.
- R8: In the configuration register, bits 5:0 hold the interrupt domain number, bit 6 the debug allow and bit 7 the trace allow. Bits 22 and 23 hold two mode selects, bits 27:24 one QoS level and bits 31:28 another. Bits 21:8, and every bit above 31, read zero. A field whose feature is disabled reads zero.
- R9: An access to either register with privilege below machine (priv != 2'b11) raises `acc_illegal`, returns read data 0 and leaves both registers unchanged.
- R10: `prot_active` is 1 exactly when `eff_priv` is not machine (2'b11).
- R11: A legal write changes the read data and the protection outputs from the next clock edge onward. Read data is combinational from the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_addr | input | 12 | CSR address |
| acc_we | input | 1 | Write enable |
| acc_wdata | input | XLEN | Write data |
| acc_priv | input | 2 | Requester privilege (3 = machine) |
| acc_rdata | output | XLEN | Legalized read data |
| acc_hit | output | 1 | Address selects one of the two registers |
| acc_illegal | output | 1 | Hit from a non-machine privilege |
| eff_priv | input | 2 | Current effective privilege |
| prot_mode | output | 4 | Stored protection mode |
| prot_sdid | output | 6 | Stored domain ID |
| prot_ppn | output | 44 | Stored root page number (upper bits zero at XLEN=32) |
| prot_active | output | 1 | Tables apply at the current effective privilege |

## Verification
The bench builds two instances. The first is 64 bits wide with ID_BITS=4 and modes 0, 1 and 3 supported. Its interrupt, debug and QoS fields are present and its trace bit is absent. This instance reaches partial ID masking, an unsupported mode inside the defined range (mode 2), a reserved mode (15), 32 KiB alignment in mode 3 and a configuration register that is only partly populated. The second is 32 bits wide with ID_BITS=0, modes 0 and 1 supported and no optional fields. It covers the narrow layout, an ID that is fully absent and a configuration register that reads zero throughout.

// File: rtl/sd_csr_pkg.sv
package sd_csr_pkg;

    localparam logic [11:0] ADDR_PTR = 12'h382;
    localparam logic [11:0] ADDR_CFG = 12'h74E;
    localparam logic [1:0]  PRIV_MACH = 2'b11;
    localparam int          SDID_MAX = 6;
    localparam int          PPN_MAXW = 44;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PTR  = 2'd1,
        SEL_CFG  = 2'd2
    } acc_sel_e;

    typedef struct packed {
        logic [3:0]          mode;
        logic [SDID_MAX-1:0] sdid;
        logic [PPN_MAXW-1:0] ppn;
    } ptr_fields_t;

    // Split a raw register word into fields for the chosen width.
    function automatic ptr_fields_t ptr_unpack(input logic [63:0] w, input bit wide);
        ptr_fields_t f;
        if (wide) begin
            f.mode = w[63:60];
            f.sdid = w[57:52];
            f.ppn  = w[43:0];
        end else begin
            f.mode = {2'b00, w[31:30]};
            f.sdid = w[27:22];
            f.ppn  = {22'd0, w[21:0]};
        end
        return f;
    endfunction

    // Assemble a register word from fields; reserved positions stay zero.
    function automatic logic [63:0] ptr_pack(input ptr_fields_t f, input bit wide);
        logic [63:0] w;
        w = '0;
        if (wide) begin
            w[63:60] = f.mode;
            w[57:52] = f.sdid;
            w[43:0]  = f.ppn;
        end else begin
            w[31:30] = f.mode[1:0];
            w[27:22] = f.sdid;
            w[21:0]  = f.ppn[21:0];
        end
        return w;
    endfunction

    // Writable bits of the configuration register for a feature set.
    function automatic logic [31:0] cfg_wmask(input bit intr, input bit dbg,
                                              input bit trc, input bit qos);
        logic [31:0] m;
        m = '0;
        if (intr) m[5:0]   = '1;
        if (dbg)  m[6]     = 1'b1;
        if (trc)  m[7]     = 1'b1;
        if (qos)  m[31:22] = '1;
        return m;
    endfunction

endpackage

// File: rtl/sd_csr_decode.sv
module sd_csr_decode
    import sd_csr_pkg::*;
(
    input  logic        acc_valid,
    input  logic [11:0] acc_addr,
    input  logic        acc_we,
    input  logic [1:0]  acc_priv,
    output acc_sel_e    sel,
    output logic        hit,
    output logic        illegal,
    output logic        wr_ptr,
    output logic        wr_cfg
);
    logic allowed;

    always_comb begin
        sel = SEL_NONE;
        if (acc_valid) begin
            unique case (acc_addr)
                ADDR_PTR: sel = SEL_PTR;
                ADDR_CFG: sel = SEL_CFG;
                default:  sel = SEL_NONE;
            endcase
        end
    end

    assign hit     = (sel != SEL_NONE);
    assign allowed = (acc_priv == PRIV_MACH);
    assign illegal = hit && !allowed;
    assign wr_ptr  = (sel == SEL_PTR) && allowed && acc_we;
    assign wr_cfg  = (sel == SEL_CFG) && allowed && acc_we;

endmodule

// File: rtl/sd_ptr_reg.sv
module sd_ptr_reg
    import sd_csr_pkg::*;
#(
    parameter int          XLEN      = 64,
    parameter int          ID_BITS   = 6,
    parameter logic [15:0] MODE_MASK = 16'h000F
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [63:0] wdata,
    output ptr_fields_t cur
);
    localparam bit          WIDE     = (XLEN == 64);
    localparam int          TOP_MODE = WIDE ? 3 : 1;
    localparam logic [SDID_MAX-1:0] ID_KEEP =
        (ID_BITS == 0) ? '0 : SDID_MAX'((64'd1 << ID_BITS) - 64'd1);

    logic [15:0] mode_ok;
    ptr_fields_t raw, legal, state_q;

    // Per-mode support vector: mode 0 always, others only if defined and enabled.
    generate
        for (genvar m = 0; m < 16; m++) begin : g_mode_ok
            if (m == 0) begin : g_bare
                assign mode_ok[m] = 1'b1;
            end else if (m <= TOP_MODE) begin : g_def
                assign mode_ok[m] = MODE_MASK[m];
            end else begin : g_rsvd
                assign mode_ok[m] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        raw        = ptr_unpack(wdata, WIDE);
        legal      = raw;
        legal.mode = mode_ok[raw.mode] ? raw.mode : 4'd0;
        legal.sdid = raw.sdid & ID_KEEP;
        if (WIDE && legal.mode == 4'd3)
            legal.ppn[2:0] = 3'b000;
    end

    always_ff @(posedge clk) begin
        if (rst)        state_q <= '0;
        else if (wr_en) state_q <= legal;
    end

    assign cur = state_q;

    assert_mode_legal_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cur.mode == 4'd0) || (MODE_MASK[cur.mode] && cur.mode <= 4'(TOP_MODE)));

    assert_sdid_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (cur.sdid & ~ID_KEEP) == '0);

    assert_align_R7: assert property (@(posedge clk) disable iff (rst)
        (WIDE && cur.mode == 4'd3) |-> (cur.ppn[2:0] == 3'b000));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cur));

endmodule

// File: rtl/sd_cfg_reg.sv
module sd_cfg_reg
    import sd_csr_pkg::*;
#(
    parameter bit HAS_INTR = 1'b1,
    parameter bit HAS_DBG  = 1'b1,
    parameter bit HAS_TRC  = 1'b1,
    parameter bit HAS_QOS  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] cur
);
    localparam logic [31:0] KEEP = cfg_wmask(HAS_INTR, HAS_DBG, HAS_TRC, HAS_QOS);
    localparam bit          ANY  = HAS_INTR || HAS_DBG || HAS_TRC || HAS_QOS;

    generate
        if (ANY) begin : g_store
            logic [31:0] q;
            always_ff @(posedge clk) begin
                if (rst)        q <= '0;
                else if (wr_en) q <= wdata & KEEP;
            end
            assign cur = q;
        end else begin : g_zero
            assign cur = '0;
        end
    endgenerate

    assert_cfg_rsvd_R8: assert property (@(posedge clk) disable iff (rst)
        (cur & ~KEEP) == 32'd0);

endmodule

// File: rtl/sd_csr_pair.sv
module sd_csr_pair
    import sd_csr_pkg::*;
#(
    parameter int          XLEN      = 64,
    parameter int          ID_BITS   = 6,
    parameter logic [15:0] MODE_MASK = 16'h000F,
    parameter bit          HAS_INTR  = 1'b1,
    parameter bit          HAS_DBG   = 1'b1,
    parameter bit          HAS_TRC   = 1'b1,
    parameter bit          HAS_QOS   = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic [11:0]     acc_addr,
    input  logic            acc_we,
    input  logic [XLEN-1:0] acc_wdata,
    input  logic [1:0]      acc_priv,
    output logic [XLEN-1:0] acc_rdata,
    output logic            acc_hit,
    output logic            acc_illegal,
    input  logic [1:0]      eff_priv,
    output logic [3:0]      prot_mode,
    output logic [5:0]      prot_sdid,
    output logic [43:0]     prot_ppn,
    output logic            prot_active
);
    localparam bit WIDE = (XLEN == 64);

    acc_sel_e    sel;
    logic        wr_ptr, wr_cfg;
    logic [63:0] wide_wdata, ptr_word, rd_word;
    logic [31:0] cfg_word;
    ptr_fields_t ptr_cur;

    assign wide_wdata = 64'(acc_wdata);

    sd_csr_decode u_dec (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_we    (acc_we),
        .acc_priv  (acc_priv),
        .sel       (sel),
        .hit       (acc_hit),
        .illegal   (acc_illegal),
        .wr_ptr    (wr_ptr),
        .wr_cfg    (wr_cfg)
    );

    sd_ptr_reg #(
        .XLEN      (XLEN),
        .ID_BITS   (ID_BITS),
        .MODE_MASK (MODE_MASK)
    ) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_ptr),
        .wdata (wide_wdata),
        .cur   (ptr_cur)
    );

    sd_cfg_reg #(
        .HAS_INTR (HAS_INTR),
        .HAS_DBG  (HAS_DBG),
        .HAS_TRC  (HAS_TRC),
        .HAS_QOS  (HAS_QOS)
    ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_cfg),
        .wdata (wide_wdata[31:0]),
        .cur   (cfg_word)
    );

    assign ptr_word = ptr_pack(ptr_cur, WIDE);

    always_comb begin
        rd_word = '0;
        if (!acc_illegal) begin
            unique case (sel)
                SEL_PTR: rd_word = ptr_word;
                SEL_CFG: rd_word = {32'd0, cfg_word};
                default: rd_word = '0;
            endcase
        end
    end

    assign acc_rdata   = rd_word[XLEN-1:0];
    assign prot_mode   = ptr_cur.mode;
    assign prot_sdid   = ptr_cur.sdid;
    assign prot_ppn    = ptr_cur.ppn;
    assign prot_active = (eff_priv != PRIV_MACH);

    assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (rst)
        acc_illegal |-> (acc_rdata == '0));

    assert_no_low_priv_write_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_priv != PRIV_MACH) |=> $stable(prot_mode) && $stable(prot_sdid)
                                                 && $stable(prot_ppn));

    assert_miss_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !acc_hit |-> (acc_rdata == '0));

    assert_miss_illegal_R2: assert property (@(posedge clk) disable iff (rst)
        acc_illegal |-> acc_hit);

endmodule

// File: tb/sim_sd_csr_pair.sv
module sim_sd_csr_pair;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // Instance u0: 64-bit, 4 ID bits, modes 0/1/3, trace field absent.
    logic        a_valid = 0, a_we = 0;
    logic [11:0] a_addr = '0;
    logic [63:0] a_wdata = '0, a_rdata;
    logic [1:0]  a_priv = 2'b11, a_eff = 2'b11;
    logic        a_hit, a_ill, a_act;
    logic [3:0]  a_mode;
    logic [5:0]  a_sdid;
    logic [43:0] a_ppn;

    // Instance u1: 32-bit, no ID bits, modes 0/1, no optional fields.
    logic        b_valid = 0, b_we = 0;
    logic [11:0] b_addr = '0;
    logic [31:0] b_wdata = '0, b_rdata;
    logic [1:0]  b_priv = 2'b11, b_eff = 2'b11;
    logic        b_hit, b_ill, b_act;
    logic [3:0]  b_mode;
    logic [5:0]  b_sdid;
    logic [43:0] b_ppn;

    sd_csr_pair #(.XLEN(64), .ID_BITS(4), .MODE_MASK(16'h000B),
                  .HAS_INTR(1), .HAS_DBG(1), .HAS_TRC(0), .HAS_QOS(1)) u0 (
        .clk(clk), .rst(rst), .acc_valid(a_valid), .acc_addr(a_addr), .acc_we(a_we),
        .acc_wdata(a_wdata), .acc_priv(a_priv), .acc_rdata(a_rdata), .acc_hit(a_hit),
        .acc_illegal(a_ill), .eff_priv(a_eff), .prot_mode(a_mode), .prot_sdid(a_sdid),
        .prot_ppn(a_ppn), .prot_active(a_act));

    sd_csr_pair #(.XLEN(32), .ID_BITS(0), .MODE_MASK(16'h0003),
                  .HAS_INTR(0), .HAS_DBG(0), .HAS_TRC(0), .HAS_QOS(0)) u1 (
        .clk(clk), .rst(rst), .acc_valid(b_valid), .acc_addr(b_addr), .acc_we(b_we),
        .acc_wdata(b_wdata), .acc_priv(b_priv), .acc_rdata(b_rdata), .acc_hit(b_hit),
        .acc_illegal(b_ill), .eff_priv(b_eff), .prot_mode(b_mode), .prot_sdid(b_sdid),
        .prot_ppn(b_ppn), .prot_active(b_act));

    function automatic logic [63:0] w64(input logic [3:0] m, input logic [5:0] id,
                                        input logic [43:0] p);
        return {m, 2'b00, id, 8'h00, p};
    endfunction

    function automatic logic [31:0] w32(input logic [1:0] m, input logic [5:0] id,
                                        input logic [21:0] p);
        return {m, 2'b00, id, p};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle access on instance u0 (drive at negedge, commit on next posedge).
    task automatic a_write(input logic [11:0] ad, input logic [63:0] d, input logic [1:0] pv);
        @(negedge clk);
        a_valid = 1; a_we = 1; a_addr = ad; a_wdata = d; a_priv = pv;
        @(negedge clk);
        a_valid = 0; a_we = 0; a_priv = 2'b11;
    endtask

    task automatic a_read(input logic [11:0] ad, input logic [1:0] pv, output logic [63:0] d);
        a_valid = 1; a_we = 0; a_addr = ad; a_priv = pv;
        #1 d = a_rdata;
    endtask

    task automatic b_write(input logic [11:0] ad, input logic [31:0] d);
        @(negedge clk);
        b_valid = 1; b_we = 1; b_addr = ad; b_wdata = d;
        @(negedge clk);
        b_valid = 0; b_we = 0;
    endtask

    task automatic b_read(input logic [11:0] ad, output logic [31:0] d);
        b_valid = 1; b_we = 0; b_addr = ad;
        #1 d = b_rdata;
    endtask

    task automatic t_reset;
        logic [63:0] r;
        a_read(12'h382, 2'b11, r); check("R1 ptr reset", r, 64'd0);
        a_read(12'h74E, 2'b11, r); check("R1 cfg reset", r, 64'd0);
        check("R1 outputs reset", {a_mode, a_sdid, a_ppn}, 64'd0);
        a_valid = 0;
    endtask

    task automatic t_all_ones_wide;
        logic [63:0] r;
        a_write(12'h382, '1, 2'b11);
        a_read(12'h382, 2'b11, r);
        // R6 mode 15 reserved -> 0; R5 4 ID bits; R3 reserved bits zero
        check("R6/R5/R3 all ones", r, 64'h00F0_0FFF_FFFF_FFFF);
        check("R5 prot_sdid", {58'd0, a_sdid}, 64'h0F);
        check("R6 prot_mode", {60'd0, a_mode}, 64'd0);
        a_valid = 0;
    endtask

    task automatic t_mode3_align;
        logic [63:0] r;
        a_write(12'h382, w64(4'd3, 6'h35, 44'h123_4567_89AF), 2'b11);
        a_read(12'h382, 2'b11, r);
        check("R7 mode3 aligned", r, w64(4'd3, 6'h05, 44'h123_4567_89A8));
        check("R11 prot_ppn", {20'd0, a_ppn}, 64'h123_4567_89A8);
        a_valid = 0;
    endtask

    task automatic t_mode2_unsupported;
        logic [63:0] r;
        a_write(12'h382, w64(4'd2, 6'h2A, 44'h0AB_CDEF_0127), 2'b11);
        a_read(12'h382, 2'b11, r);
        check("R6 mode2 -> bare, fields kept", r, w64(4'd0, 6'h0A, 44'h0AB_CDEF_0127));
        a_valid = 0;
        a_write(12'h382, w64(4'd1, 6'h07, 44'h000_0000_0007), 2'b11);
        a_read(12'h382, 2'b11, r);
        check("R3 mode1 low ppn bits kept", r, w64(4'd1, 6'h07, 44'h7));
        a_valid = 0;
    endtask

    task automatic t_cfg_wide;
        logic [63:0] r;
        a_write(12'h74E, '1, 2'b11);
        a_read(12'h74E, 2'b11, r);
        check("R8 cfg partial features", r, 64'h0000_0000_FFC0_007F);
        a_valid = 0;
        a_write(12'h74E, 64'h0000_0000_5A00_0F95, 2'b11);
        a_read(12'h74E, 2'b11, r);
        check("R8 cfg pattern", r, 64'h0000_0000_5A00_0015);
        a_valid = 0;
    endtask

    task automatic t_low_priv;
        logic [63:0] r;
        a_write(12'h382, w64(4'd3, 6'h01, 44'hFFF_0000_0000), 2'b01);
        a_read(12'h382, 2'b01, r);
        check("R9 illegal flag", {63'd0, a_ill}, 64'd1);
        check("R9 illegal rdata zero", r, 64'd0);
        a_read(12'h382, 2'b11, r);
        check("R9 ptr unchanged", r, w64(4'd1, 6'h07, 44'h7));
        a_valid = 0;
        a_write(12'h74E, 64'd0, 2'b00);
        a_read(12'h74E, 2'b11, r);
        check("R9 cfg unchanged", r, 64'h0000_0000_5A00_0015);
        a_valid = 0;
    endtask

    task automatic t_other_addr;
        logic [63:0] r;
        a_write(12'h383, '1, 2'b11);
        a_read(12'h383, 2'b11, r);
        check("R2 miss hit", {63'd0, a_hit}, 64'd0);
        check("R2 miss rdata", r, 64'd0);
        a_read(12'h382, 2'b11, r);
        check("R2 ptr untouched", r, w64(4'd1, 6'h07, 44'h7));
        a_read(12'h74E, 2'b11, r);
        check("R2 cfg untouched", r, 64'h0000_0000_5A00_0015);
        a_valid = 0;
    endtask

    task automatic t_active;
        a_eff = 2'b11; #1 check("R10 machine inactive", {63'd0, a_act}, 64'd0);
        a_eff = 2'b01; #1 check("R10 supervisor active", {63'd0, a_act}, 64'd1);
        a_eff = 2'b00; #1 check("R10 user active", {63'd0, a_act}, 64'd1);
    endtask

    task automatic t_narrow;
        logic [31:0] r;
        b_write(12'h382, '1);
        b_read(12'h382, r);
        check("R4/R5/R6 narrow all ones", {32'd0, r}, 64'h003F_FFFF);
        b_valid = 0;
        b_write(12'h382, w32(2'd1, 6'h3F, 22'h2A_AAAA));
        b_read(12'h382, r);
        check("R4 narrow mode1", {32'd0, r}, 64'h402A_AAAA);
        check("R4 narrow prot_mode", {60'd0, b_mode}, 64'd1);
        b_valid = 0;
        b_write(12'h74E, '1);
        b_read(12'h74E, r);
        check("R8 cfg no features", {32'd0, r}, 64'd0);
        b_valid = 0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        t_reset();
        t_all_ones_wide();
        t_mode3_align();
        t_mode2_unsupported();
        t_cfg_wide();
        t_low_priv();
        t_other_addr();
        t_active();
        t_narrow();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule